// File: doc/BRIEF.md
# Run-Time Programmable Complex Sample Gain

This block scales a stream of signed complex samples by a gain that software sets at run time. Each data-clock cycle may carry one sample (a real part, an imaginary part and a valid flag). A fixed number of cycles later, the block presents the full-precision product with a matching valid flag. Nothing is rounded and nothing is saturated. The only bit dropped is the duplicated sign bit of a signed-by-signed product.

Two gain words, real and imaginary, are written over two separate simple write ports. These ports run in a slow bus clock domain. A new gain passes to the data clock domain through a toggle handshake, so the multiplier always sees a whole gain word and never a mix of old and new bits. While a transfer is in flight, later writes are collected, and the most recent values follow in the next transfer.

A build parameter selects between two modes:
- **Real-gain mode:** the single real gain scales both components of the sample.
- **Complex-gain mode:** the block forms a full complex product.

Top module: `cgain_stream`

## Requirements
- R1: With gain width G and input width N, real-gain mode produces outputs of G+N-1 bits and complex-gain mode produces outputs of G+N bits. Each elementary product is kept to its lowest G+N-1 bits in two's complement, so the single case (-2^(G-1))·(-2^(N-1)) wraps to -2^(G+N-2).
- R2: In real-gain mode (COMPLEX_GAIN=0), the output real part is gRe·xRe and the output imaginary part is gRe·xIm. The imaginary gain word has no effect on the output.
- R3: In complex-gain mode (COMPLEX_GAIN=1), the output real part is gRe·xRe − gIm·xIm and the output imaginary part is gRe·xIm + gIm·xRe.
- R4: After reset, the real gain equals GAIN_INIT_RE (default 1) and the imaginary gain equals GAIN_INIT_IM (default 0). With the defaults, samples pass through unscaled.
- R5: Each input sample appears at the output exactly 3 data-clock cycles after it is presented. outValid equals inValid delayed by 3 cycles, so gaps in the input stream reappear unchanged.
- R6: A write changes a gain word only when its address is 0. A write to any other address has no effect on the gain.
- R7: A written gain takes effect in the data domain after the clock-domain crossing. When two writes to the same gain arrive in back-to-back bus cycles, the later value is the one that remains in force.
- R8: A gain change during a continuous stream neither drops nor duplicates a sample. Every output uses either the complete old gain or the complete new gain, and once the new gain appears the old one never returns.
- R9: During reset and until the first valid input has passed through the pipeline, outValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock for the gain write ports |
| busRst | input | 1 | Synchronous active-high reset, bus domain |
| dataClk | input | 1 | Sample clock |
| dataRst | input | 1 | Synchronous active-high reset, data domain |
| reWrEn | input | 1 | Write strobe for the real gain |
| reWrAddr | input | ADDR_W | Word address for the real gain write (gain at 0) |
| reWrData | input | GAIN_W | Real gain value, signed |
| imWrEn | input | 1 | Write strobe for the imaginary gain |
| imWrAddr | input | ADDR_W | Word address for the imaginary gain write (gain at 0) |
| imWrData | input | GAIN_W | Imaginary gain value, signed |
| inValid | input | 1 | Input sample qualifier |
| inRe | input | IN_W | Input real part, signed |
| inIm | input | IN_W | Input imaginary part, signed |
| outValid | output | 1 | Output sample qualifier |
| outRe | output | OUT_W | Output real part, signed |
| outIm | output | OUT_W | Output imaginary part, signed |

## Verification
The bench instantiates two copies of the block, both with GAIN_W=8 and IN_W=9. One copy uses complex gain and the other uses real gain. Both copies receive the same stream and the same writes, so a single run covers R2 and R3 side by side, including the case where the imaginary gain must be ignored. The narrow 8-bit gain makes the extreme product -128·-256 reachable, which exercises the wrap at 16 and 17 output bits. Separate bus and data clocks, 20 ns and 5 ns, place gain writes at arbitrary phases of a continuous sample stream.

// File: rtl/cgain_pkg.sv
package cgain_pkg;

  // Strobes sent from the gain-transfer control to the multiplier datapath.
  typedef struct packed {
    logic loadGain;  // one data-clock pulse: held gain words are stable, take them
  } gainCtrl_t;

endpackage

// File: rtl/cgain_ctrl.sv
module cgain_ctrl
  import cgain_pkg::*;
#(
  parameter int GAIN_W       = 16,
  parameter int ADDR_W       = 2,
  parameter int GAIN_INIT_RE = 1,
  parameter int GAIN_INIT_IM = 0
) (
  input  logic              busClk,
  input  logic              busRst,
  input  logic              reWrEn,
  input  logic [ADDR_W-1:0] reWrAddr,
  input  logic [GAIN_W-1:0] reWrData,
  input  logic              imWrEn,
  input  logic [ADDR_W-1:0] imWrAddr,
  input  logic [GAIN_W-1:0] imWrData,
  input  logic              dataClk,
  input  logic              dataRst,
  output gainCtrl_t         ctrl,
  output logic [GAIN_W-1:0] heldRe,
  output logic [GAIN_W-1:0] heldIm
);

  localparam logic [GAIN_W-1:0] INIT_RE = GAIN_W'(GAIN_INIT_RE);
  localparam logic [GAIN_W-1:0] INIT_IM = GAIN_W'(GAIN_INIT_IM);

  // ---------------- bus domain ----------------
  logic [GAIN_W-1:0] regRe, regIm;
  logic              dirty;
  logic              reqTgl;
  logic              ackS1, ackS2;
  logic              ackTgl;
  logic              reHit, imHit, busy, launch;

  assign reHit  = reWrEn && (reWrAddr == '0);
  assign imHit  = imWrEn && (imWrAddr == '0);
  assign busy   = reqTgl != ackS2;
  assign launch = dirty && !busy;

  always_ff @(posedge busClk) begin
    if (busRst) begin
      regRe  <= INIT_RE;
      regIm  <= INIT_IM;
      heldRe <= INIT_RE;
      heldIm <= INIT_IM;
      dirty  <= 1'b0;
      reqTgl <= 1'b0;
      ackS1  <= 1'b0;
      ackS2  <= 1'b0;
    end else begin
      if (reHit) regRe <= reWrData;
      if (imHit) regIm <= imWrData;
      ackS1 <= ackTgl;
      ackS2 <= ackS1;
      if (launch) begin
        heldRe <= regRe;
        heldIm <= regIm;
        reqTgl <= ~reqTgl;
      end
      // a write landing in the launch cycle keeps the flag set for another round
      dirty <= (dirty && !launch) || reHit || imHit;
    end
  end

  // ---------------- data domain ----------------
  logic reqS1, reqS2, reqS3;

  always_ff @(posedge dataClk) begin
    if (dataRst) begin
      reqS1 <= 1'b0;
      reqS2 <= 1'b0;
      reqS3 <= 1'b0;
    end else begin
      reqS1 <= reqTgl;
      reqS2 <= reqS1;
      reqS3 <= reqS2;
    end
  end

  assign ackTgl = reqS3;

  always_comb begin
    ctrl          = '0;
    ctrl.loadGain = reqS2 ^ reqS3;
  end

  // ---------------- assertions ----------------
  AST_HELD_FROZEN_IN_FLIGHT: assert property (@(posedge busClk) disable iff (busRst)
    busy |=> ($stable(heldRe) && $stable(heldIm)))
    else $error("held gain moved during transfer"); // R8

  AST_ONE_TRANSFER_IN_FLIGHT: assert property (@(posedge busClk) disable iff (busRst)
    (reqTgl != $past(reqTgl)) |-> ($past(reqTgl) == $past(ackS2)))
    else $error("new request before acknowledge"); // R7

  AST_OTHER_ADDR_IGNORED: assert property (@(posedge busClk) disable iff (busRst)
    (reWrEn && reWrAddr != '0) |=> $stable(regRe))
    else $error("real gain changed by off-address write"); // R6

  AST_LOAD_SINGLE_PULSE: assert property (@(posedge dataClk) disable iff (dataRst)
    ctrl.loadGain |=> !ctrl.loadGain)
    else $error("load strobe longer than one cycle"); // R7

endmodule

// File: rtl/cgain_dp.sv
module cgain_dp
  import cgain_pkg::*;
#(
  parameter int GAIN_W       = 16,
  parameter int IN_W         = 9,
  parameter bit COMPLEX_GAIN = 1'b0,
  parameter int GAIN_INIT_RE = 1,
  parameter int GAIN_INIT_IM = 0,
  parameter int OUT_W        = GAIN_W + IN_W - 1
) (
  input  logic              dataClk,
  input  logic              dataRst,
  input  gainCtrl_t         ctrl,
  input  logic [GAIN_W-1:0] heldRe,
  input  logic [GAIN_W-1:0] heldIm,
  input  logic              inValid,
  input  logic [IN_W-1:0]   inRe,
  input  logic [IN_W-1:0]   inIm,
  output logic              outValid,
  output logic [OUT_W-1:0]  outRe,
  output logic [OUT_W-1:0]  outIm
);

  localparam int FULL_W = GAIN_W + IN_W;
  localparam int PROD_W = FULL_W - 1;

  // active gain (real part always present)
  logic signed [GAIN_W-1:0] gRe;

  always_ff @(posedge dataClk) begin
    if (dataRst)            gRe <= GAIN_W'(GAIN_INIT_RE);
    else if (ctrl.loadGain) gRe <= heldRe;
  end

  // stage 1: sample capture
  logic                   v1, v2;
  logic signed [IN_W-1:0] xRe, xIm;

  always_ff @(posedge dataClk) begin
    if (dataRst) begin
      v1  <= 1'b0;
      v2  <= 1'b0;
      xRe <= '0;
      xIm <= '0;
      outValid <= 1'b0;
    end else begin
      v1  <= inValid;
      xRe <= inRe;
      xIm <= inIm;
      v2  <= v1;
      outValid <= v2;
    end
  end

  generate
    if (COMPLEX_GAIN) begin : g_cplx
      logic signed [GAIN_W-1:0] gIm;
      logic signed [PROD_W-1:0] pRR, pII, pRI, pIR;

      always_ff @(posedge dataClk) begin
        if (dataRst)            gIm <= GAIN_W'(GAIN_INIT_IM);
        else if (ctrl.loadGain) gIm <= heldIm;
      end

      // stage 2: four elementary products
      always_ff @(posedge dataClk) begin
        if (dataRst) begin
          pRR <= '0; pII <= '0; pRI <= '0; pIR <= '0;
        end else begin
          pRR <= PROD_W'(FULL_W'(gRe) * FULL_W'(xRe));
          pII <= PROD_W'(FULL_W'(gIm) * FULL_W'(xIm));
          pRI <= PROD_W'(FULL_W'(gRe) * FULL_W'(xIm));
          pIR <= PROD_W'(FULL_W'(gIm) * FULL_W'(xRe));
        end
      end

      // stage 3: combine with one bit of headroom
      always_ff @(posedge dataClk) begin
        if (dataRst) begin
          outRe <= '0;
          outIm <= '0;
        end else begin
          outRe <= OUT_W'(pRR) - OUT_W'(pII);
          outIm <= OUT_W'(pRI) + OUT_W'(pIR);
        end
      end
    end else begin : g_real
      logic signed [PROD_W-1:0] pRe, pIm;
      logic                     unusedIm;

      assign unusedIm = ^heldIm;

      always_ff @(posedge dataClk) begin
        if (dataRst) begin
          pRe <= '0; pIm <= '0;
        end else begin
          pRe <= PROD_W'(FULL_W'(gRe) * FULL_W'(xRe));
          pIm <= PROD_W'(FULL_W'(gRe) * FULL_W'(xIm));
        end
      end

      always_ff @(posedge dataClk) begin
        if (dataRst) begin
          outRe <= '0;
          outIm <= '0;
        end else begin
          outRe <= OUT_W'(pRe);
          outIm <= OUT_W'(pIm);
        end
      end
    end
  endgenerate

  // ---------------- assertions ----------------
  logic [1:0] warm;

  always_ff @(posedge dataClk) begin
    if (dataRst)            warm <= '0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  AST_VALID_LAG_THREE: assert property (@(posedge dataClk) disable iff (dataRst)
    (warm == 2'd3) |-> (outValid == $past(inValid, 3)))
    else $error("output valid not aligned to input"); // R5

  AST_IDLE_AFTER_RESET: assert property (@(posedge dataClk) disable iff (dataRst)
    (warm != 2'd3) |-> !outValid)
    else $error("valid before pipeline filled"); // R9

endmodule

// File: rtl/cgain_stream.sv
module cgain_stream
  import cgain_pkg::*;
#(
  parameter int GAIN_W       = 16,
  parameter int IN_W         = 9,
  parameter int ADDR_W       = 2,
  parameter bit COMPLEX_GAIN = 1'b0,
  parameter int GAIN_INIT_RE = 1,
  parameter int GAIN_INIT_IM = 0,
  localparam int OUT_W       = GAIN_W + IN_W - 1 + (COMPLEX_GAIN ? 1 : 0)
) (
  input  logic              busClk,
  input  logic              busRst,
  input  logic              dataClk,
  input  logic              dataRst,
  input  logic              reWrEn,
  input  logic [ADDR_W-1:0] reWrAddr,
  input  logic [GAIN_W-1:0] reWrData,
  input  logic              imWrEn,
  input  logic [ADDR_W-1:0] imWrAddr,
  input  logic [GAIN_W-1:0] imWrData,
  input  logic              inValid,
  input  logic [IN_W-1:0]   inRe,
  input  logic [IN_W-1:0]   inIm,
  output logic              outValid,
  output logic [OUT_W-1:0]  outRe,
  output logic [OUT_W-1:0]  outIm
);

  gainCtrl_t         ctrl;
  logic [GAIN_W-1:0] heldRe, heldIm;

  cgain_ctrl #(
    .GAIN_W(GAIN_W), .ADDR_W(ADDR_W),
    .GAIN_INIT_RE(GAIN_INIT_RE), .GAIN_INIT_IM(GAIN_INIT_IM)
  ) uCtrl (
    .busClk(busClk), .busRst(busRst),
    .reWrEn(reWrEn), .reWrAddr(reWrAddr), .reWrData(reWrData),
    .imWrEn(imWrEn), .imWrAddr(imWrAddr), .imWrData(imWrData),
    .dataClk(dataClk), .dataRst(dataRst),
    .ctrl(ctrl), .heldRe(heldRe), .heldIm(heldIm)
  );

  cgain_dp #(
    .GAIN_W(GAIN_W), .IN_W(IN_W), .COMPLEX_GAIN(COMPLEX_GAIN),
    .GAIN_INIT_RE(GAIN_INIT_RE), .GAIN_INIT_IM(GAIN_INIT_IM), .OUT_W(OUT_W)
  ) uDp (
    .dataClk(dataClk), .dataRst(dataRst),
    .ctrl(ctrl), .heldRe(heldRe), .heldIm(heldIm),
    .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .outValid(outValid), .outRe(outRe), .outIm(outIm)
  );

endmodule

// File: tb/tb_cgain_stream.sv
`timescale 1ns/1ps
module tb_cgain_stream;

  localparam int GW = 8;
  localparam int IW = 9;
  localparam int PW = GW + IW - 1;

  logic dataClk = 0, busClk = 0;
  logic dataRst = 1, busRst = 1;
  always #2.5 dataClk = ~dataClk;
  always #10  busClk  = ~busClk;

  logic          reWrEn = 0, imWrEn = 0;
  logic [1:0]    reWrAddr = 0, imWrAddr = 0;
  logic [GW-1:0] reWrData = 0, imWrData = 0;
  logic          inValid = 0;
  logic [IW-1:0] inRe = 0, inIm = 0;

  logic          cValid, rValid;
  logic [PW:0]   cRe, cIm;
  logic [PW-1:0] rRe, rIm;

  cgain_stream #(.GAIN_W(GW), .IN_W(IW), .COMPLEX_GAIN(1'b1)) dut (
    .busClk(busClk), .busRst(busRst), .dataClk(dataClk), .dataRst(dataRst),
    .reWrEn(reWrEn), .reWrAddr(reWrAddr), .reWrData(reWrData),
    .imWrEn(imWrEn), .imWrAddr(imWrAddr), .imWrData(imWrData),
    .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .outValid(cValid), .outRe(cRe), .outIm(cIm));

  cgain_stream #(.GAIN_W(GW), .IN_W(IW), .COMPLEX_GAIN(1'b0)) dutReal (
    .busClk(busClk), .busRst(busRst), .dataClk(dataClk), .dataRst(dataRst),
    .reWrEn(reWrEn), .reWrAddr(reWrAddr), .reWrData(reWrData),
    .imWrEn(imWrEn), .imWrAddr(imWrAddr), .imWrData(imWrData),
    .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .outValid(rValid), .outRe(rRe), .outIm(rIm));

  int checks = 0, fails = 0;
  bit finished = 0;

  // model state
  int  gr = 1, gi = 0;
  bit  autoCheck = 1;
  string tag = "R4";
  bit  hV[0:2];
  int  hRe[0:2], hIm[0:2];

  function automatic int wrapTo(int v, int w);
    int m;
    m = v & ((1 << w) - 1);
    if (m >= (1 << (w - 1))) m = m - (1 << w);
    return m;
  endfunction

  function automatic int eCRe(int a, int b, int xr, int xi);
    return wrapTo(wrapTo(a * xr, PW) - wrapTo(b * xi, PW), PW + 1);
  endfunction
  function automatic int eCIm(int a, int b, int xr, int xi);
    return wrapTo(wrapTo(a * xi, PW) + wrapTo(b * xr, PW), PW + 1);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareOut();
    chk(tag, "complex valid", int'(cValid), int'(hV[2]));
    chk(tag, "real valid", int'(rValid), int'(hV[2]));
    if (hV[2]) begin
      chk(tag, "complex re", int'($signed(cRe)), eCRe(gr, gi, hRe[2], hIm[2]));
      chk(tag, "complex im", int'($signed(cIm)), eCIm(gr, gi, hRe[2], hIm[2]));
      chk(tag, "real re", int'($signed(rRe)), wrapTo(gr * hRe[2], PW));
      chk(tag, "real im", int'($signed(rIm)), wrapTo(gr * hIm[2], PW));
    end
  endtask

  // called at a falling data edge; returns at the next falling edge
  task automatic cycle(input bit v, input int re, input int im);
    inValid = v; inRe = IW'(re); inIm = IW'(im);
    hV[2] = hV[1]; hRe[2] = hRe[1]; hIm[2] = hIm[1];
    hV[1] = hV[0]; hRe[1] = hRe[0]; hIm[1] = hIm[0];
    hV[0] = v;     hRe[0] = re;     hIm[0] = im;
    @(posedge dataClk); @(negedge dataClk);
    if (autoCheck) compareOut();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0);
  endtask

  task automatic busWrite(input bit toIm, input logic [1:0] addr, input int val);
    @(negedge busClk);
    if (toIm) begin imWrEn = 1; imWrAddr = addr; imWrData = GW'(val); end
    else      begin reWrEn = 1; reWrAddr = addr; reWrData = GW'(val); end
    @(negedge busClk);
    reWrEn = 0; imWrEn = 0;
  endtask

  task automatic stream(input int n, input int seed);
    for (int k = 0; k < n; k++)
      cycle(1, ((k + seed) * 37) % 300 - 150, ((k + seed) * 53) % 400 - 200);
    idle(3);
  endtask

  task automatic setGain(input int newRe, input int newIm);
    busWrite(0, 2'd0, newRe);
    busWrite(1, 2'd0, newIm);
    idle(60);
    gr = newRe; gi = newIm;
  endtask

  // R9: quiet outputs during and right after reset
  task automatic testReset();
    for (int i = 0; i < 6; i++) begin
      @(negedge dataClk);
      chk("R9", "valid in reset (cplx)", int'(cValid), 0);
      chk("R9", "valid in reset (real)", int'(rValid), 0);
    end
    @(negedge dataClk); dataRst = 0; busRst = 0;
    tag = "R9";
    idle(4);
  endtask

  // R4: default gains pass samples through
  task automatic testDefault();
    tag = "R4";
    stream(10, 1);
  endtask

  // R2: real gain scales both parts; imaginary word ignored by the real copy
  task automatic testRealGain();
    tag = "R2";
    setGain(3, 0);
    stream(10, 5);
    setGain(-7, 0);
    stream(8, 9);
  endtask

  // R3: full complex product; R2 real copy still only uses the real word
  task automatic testComplexGain();
    tag = "R3";
    setGain(5, -3);
    stream(12, 2);
    setGain(-100, 77);
    stream(12, 20);
  endtask

  // R5: gaps in the input reappear 3 cycles later
  task automatic testGaps();
    tag = "R5";
    for (int k = 0; k < 16; k++) cycle(((k % 3) != 1), k * 11 - 80, 90 - k * 7);
    idle(3);
  endtask

  // R6: off-address writes do not move either gain
  task automatic testAddr();
    tag = "R6";
    busWrite(0, 2'd1, 77);
    busWrite(1, 2'd3, -55);
    idle(60);
    stream(8, 30);
  endtask

  // R7: back-to-back writes, last one stays
  task automatic testBackToBack();
    tag = "R7";
    busWrite(0, 2'd0, 10);
    busWrite(0, 2'd0, -9);
    busWrite(1, 2'd0, 4);
    busWrite(1, 2'd0, 2);
    idle(80);
    gr = -9; gi = 2;
    stream(10, 40);
  endtask

  // R1: the extreme product wraps into the narrowed width
  task automatic testCorner();
    tag = "R1";
    setGain(-128, 0);
    cycle(1, -256, 255);
    cycle(1, 255, -256);
    idle(3);
    chk("R1", "complex width", $bits(cRe), GW + IW);
    chk("R1", "real width", $bits(rRe), GW + IW - 1);
  endtask

  // R8: gain change mid-stream, no loss or duplication, clean switch
  task automatic testLiveChange();
    int oldRe, oldIm, newRe, newIm, eo, en, act;
    bit sw;
    oldRe = 5; oldIm = -3; newRe = 9; newIm = -3;
    setGain(oldRe, oldIm);
    autoCheck = 0; sw = 0;
    fork
      begin
        idle(0);
        repeat (3) @(negedge busClk);
        busWrite(0, 2'd0, newRe);
      end
      begin
        for (int k = 0; k < 70; k++) begin
          cycle(1, k + 1, k + 1);
          chk("R8", "valid continuity", int'(cValid), int'(hV[2]));
          if (hV[2]) begin
            eo = eCRe(oldRe, oldIm, hRe[2], hIm[2]);
            en = eCRe(newRe, newIm, hRe[2], hIm[2]);
            act = int'($signed(cRe));
            if (!sw && act == en) sw = 1;
            chk("R8", "whole-gain product", act, sw ? en : eo);
          end
        end
      end
    join
    chk("R8", "switched to new gain", int'(sw), 1);
    gr = newRe; gi = newIm;
    autoCheck = 1; tag = "R8";
    idle(3);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin hV[i] = 0; hRe[i] = 0; hIm[i] = 0; end
    testReset();
    testDefault();
    testRealGain();
    testComplexGain();
    testGaps();
    testAddr();
    testBackToBack();
    testCorner();
    testLiveChange();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule